// File: doc/BRIEF.md
# Square-Only Modular Exponentiator

This block raises a base to an exponent modulo an odd modulus. It walks the exponent from the top bit down and uses nothing but modular squaring for its heavy arithmetic. A product is rebuilt from squares through the identity x·y = ((x+y)² − x² − y²)/2. The datapath holds four operand registers. One shared arithmetic path performs a modular add, a modular square, a modular halve and a modular subtract.

The work is split into atomic patterns. Every pattern issues the same four operations in the same order, whatever the exponent bit, and dummy operations fill the slots that carry no useful result. A two-bit pattern index chooses which registers each operation reads and writes. A square always takes W cycles, so no pattern can be told apart from another by its operation profile or by its length.

A one-cycle start pulse captures the modulus, base and exponent. The done flag then rises once the result is ready and stays high until the next start.

Top module: `sqa_modexp`

## Requirements
- R1: After reset, done is 0 and result is 0.
- R2: For an odd modulus n ≥ 3 and a base m < n, the result at done equals m^d mod n, where d is the EW-bit unsigned exponent.
- R3: A start is accepted only when the block is idle, and it clears done. The operands are captured at acceptance. Later changes on modulus, base or expo, and start pulses during a run, have no effect on that run's result or length.
- R4: Counted from the clock edge that accepts start, done is first high after exactly W + 1 + (EW + 2·p)·(W + 3) edges, where p is the number of 1 bits in the exponent. The run length depends on nothing else.
- R5: Once high, done and result hold their values until the next start.
- R6: Every pattern runs one add cycle, then a square of exactly W cycles, then one halve cycle, then one subtract cycle.
- R7: A 0 exponent bit costs one pattern. A 1 bit costs three patterns, and the pattern index then advances 1 → 2 → 3 at the pattern ends.
- R8: While a run is in progress, all four operand registers stay strictly below the captured modulus.
- R9: Edge cases follow the same rule: an exponent of 0 gives 1, a base of 0 with a nonzero exponent gives 0, and a base of 1 gives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse that begins a computation when idle |
| modulus | input | W | Odd modulus n, at least 3 |
| base | input | W | Base m, below n |
| expo | input | EW | Exponent d |
| result | output | W | m^d mod n, valid while done is high |
| done | output | 1 | High from completion until the next start |

## Verification
The assertions assume that the captured modulus is odd and at least 3, and that the base is below it. Without these, the modular halving and the range invariant on the operand registers do not hold. The stimulus draws its moduli only from odd values of 3 or more and sweeps each base only below its modulus. When the inputs are disturbed in the middle of a run, they are moved to other legal values, so the block still sees only in-range operands.

// File: rtl/sqa_modexp.sv
module sqa_modexp #(
  parameter int W  = 16,
  parameter int EW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  modulus,
  input  logic [W-1:0]  base,
  input  logic [EW-1:0] expo,
  output logic [W-1:0]  result,
  output logic          done
);
  localparam int IW = (EW > 1) ? $clog2(EW) : 1;
  localparam int BW = (W > 1) ? $clog2(W) : 1;

  localparam logic [2:0] PH_IDLE = 3'd0;
  localparam logic [2:0] PH_ISQ  = 3'd1;
  localparam logic [2:0] PH_IHF  = 3'd2;
  localparam logic [2:0] PH_ADD  = 3'd3;
  localparam logic [2:0] PH_SQR  = 3'd4;
  localparam logic [2:0] PH_HALF = 3'd5;
  localparam logic [2:0] PH_SUB  = 3'd6;

  logic [3:0][W-1:0] rf;
  logic [W-1:0]      nr, acc;
  logic [EW-1:0]     dr;
  logic [IW-1:0]     i;
  logic [BW-1:0]     bidx;
  logic [2:0]        ph;
  logic [1:0]        j, sa, sb, sd;

  always_comb begin
    sa = 2'd0; sb = 2'd0; sd = 2'd0;
    case (ph)
      PH_ISQ: begin sa = 2'd1; sd = 2'd3; end
      PH_IHF: begin sa = 2'd3; sd = 2'd3; end
      PH_ADD:
        case (j)
          2'd0: begin sd = 2'd1; sa = 2'd1; sb = 2'd1; end
          2'd1: begin sd = 2'd2; sa = 2'd0; sb = 2'd1; end
          2'd2: begin sd = 2'd1; sa = 2'd1; sb = 2'd3; end
          default: begin sd = 2'd3; sa = 2'd3; sb = 2'd3; end
        endcase
      PH_SQR:
        if (j == 2'd1) begin sa = 2'd2; sd = 2'd2; end
        else           begin sa = 2'd0; sd = 2'd0; end
      PH_HALF:
        case (j)
          2'd0: begin sd = 2'd2; sa = 2'd1; end
          2'd1: begin sd = 2'd2; sa = 2'd2; end
          2'd2: begin sd = 2'd0; sa = 2'd0; end
          default: begin sd = 2'd3; sa = 2'd3; end
        endcase
      PH_SUB:
        case (j)
          2'd0: begin sd = 2'd1; sa = 2'd1; sb = 2'd2; end
          2'd1: begin sd = 2'd2; sa = 2'd2; sb = 2'd3; end
          2'd2: begin sd = 2'd0; sa = 2'd2; sb = 2'd0; end
          default: begin sd = 2'd1; sa = 2'd1; sb = 2'd3; end
        endcase
      default: ;
    endcase
  end

  logic [W-1:0] opa, opb, add_r, sub_r, half_r, dbl_r, acc_n;
  logic [W:0]   sum, dbl, addt, half_w;

  assign opa = rf[sa];
  assign opb = rf[sb];

  assign sum    = {1'b0, opa} + {1'b0, opb};
  assign add_r  = (sum >= {1'b0, nr}) ? W'(sum - {1'b0, nr}) : W'(sum);
  assign sub_r  = (opa >= opb) ? (opa - opb) : W'({1'b0, opa} + {1'b0, nr} - {1'b0, opb});
  assign half_w = opa[0] ? ({1'b0, opa} + {1'b0, nr}) : {1'b0, opa};
  assign half_r = W'(half_w >> 1);

  assign dbl   = {acc, 1'b0};
  assign dbl_r = (dbl >= {1'b0, nr}) ? W'(dbl - {1'b0, nr}) : W'(dbl);
  assign addt  = {1'b0, dbl_r} + (opa[bidx] ? {1'b0, opa} : '0);
  assign acc_n = (addt >= {1'b0, nr}) ? W'(addt - {1'b0, nr}) : W'(addt);

  logic       dbit, dec;
  logic [1:0] jn;
  assign dbit = dr[i];
  assign jn   = dbit ? ((j == 2'd3) ? 2'd1 : j + 2'd1) : 2'd0;
  assign dec  = (j == 2'd0 || j == 2'd3) ? ~dbit : (j == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf <= '0; nr <= '0; dr <= '0; acc <= '0;
      i <= '0; bidx <= '0; j <= '0; ph <= PH_IDLE; done <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE:
          if (start) begin
            rf   <= {{W{1'b0}}, W'(1), base, W'(1)};
            nr   <= modulus;
            dr   <= expo;
            j    <= 2'd0;
            i    <= IW'(EW - 1);
            acc  <= '0;
            bidx <= BW'(W - 1);
            done <= 1'b0;
            ph   <= PH_ISQ;
          end
        PH_ISQ, PH_SQR: begin
          acc <= acc_n;
          if (bidx == '0) begin
            rf[sd] <= acc_n;
            ph     <= (ph == PH_ISQ) ? PH_IHF : PH_HALF;
          end else begin
            bidx <= bidx - 1'b1;
          end
        end
        PH_IHF: begin
          rf[sd] <= half_r;
          ph     <= PH_ADD;
        end
        PH_ADD: begin
          rf[sd] <= add_r;
          acc    <= '0;
          bidx   <= BW'(W - 1);
          ph     <= PH_SQR;
        end
        PH_HALF: begin
          rf[sd] <= half_r;
          ph     <= PH_SUB;
        end
        PH_SUB: begin
          rf[sd] <= sub_r;
          j      <= jn;
          if (dec && i == '0) begin
            done <= 1'b1;
            ph   <= PH_IDLE;
          end else begin
            if (dec) i <= i - 1'b1;
            ph <= PH_ADD;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign result = rf[0];
endmodule

// File: rtl/sqa_modexp_chk.sv
module sqa_modexp_chk #(
  parameter int W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input logic [W-1:0]      result,
  input logic [2:0]        ph,
  input logic [1:0]        j,
  input logic [3:0][W-1:0] rf,
  input logic [W-1:0]      nr
);
  localparam logic [2:0] C_IDLE = 3'd0;
  localparam logic [2:0] C_ISQ  = 3'd1;
  localparam logic [2:0] C_ADD  = 3'd3;
  localparam logic [2:0] C_SQR  = 3'd4;
  localparam logic [2:0] C_HALF = 3'd5;
  localparam logic [2:0] C_SUB  = 3'd6;

  logic in_sq;
  int   sqc;
  assign in_sq = (ph == C_SQR) || (ph == C_ISQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sqc <= 0;
    else        sqc <= in_sq ? sqc + 1 : 0;
  end

  a_r8_regs_below_modulus: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != C_IDLE) |-> (rf[0] < nr && rf[1] < nr && rf[2] < nr && rf[3] < nr));

  a_r6_add_then_square: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == C_ADD) |=> (ph == C_SQR));

  a_r6_half_then_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == C_HALF) |=> (ph == C_SUB));

  a_r6_sub_then_add_or_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == C_SUB) |=> (ph == C_ADD || ph == C_IDLE));

  a_r6_square_not_short: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sq && sqc < W - 1) |=> in_sq);

  a_r6_square_not_long: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sq && sqc == W - 1) |=> !in_sq);

  a_r7_index_one_to_two: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == C_SUB && j == 2'd1) |=> (j == 2'd2));

  a_r7_index_two_to_three: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == C_SUB && j == 2'd2) |=> (j == 2'd3));

  a_r3_start_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ph == C_IDLE) |=> !done);

  a_r5_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(result)));

  a_r4_done_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ph == C_IDLE));
endmodule

bind sqa_modexp sqa_modexp_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .result(result),
  .ph(ph), .j(j), .rf(rf), .nr(nr)
);

// File: tb/sim_sqa_modexp.sv
module sim_sqa_modexp;
  localparam int W  = 8;
  localparam int EW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  modulus = '0, base = '0;
  logic [EW-1:0] expo = '0;
  logic [W-1:0]  result;
  logic          done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  sqa_modexp #(.W(W), .EW(EW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .modulus(modulus),
    .base(base), .expo(expo), .result(result), .done(done)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected under 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int ref_pow(int n, int m, int d);
    longint r = 1;
    for (int b = EW - 1; b >= 0; b--) begin
      r = (r * r) % n;
      if ((d >> b) & 1) r = (r * m) % n;
    end
    return int'(r % n);
  endfunction

  function automatic int ref_len(int d);
    int p = 0;
    for (int b = 0; b < EW; b++) p += (d >> b) & 1;
    return W + 1 + (EW + 2 * p) * (W + 3);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start(int n, int m, int d);
    @(negedge clk);
    modulus = W'(n); base = W'(m); expo = EW'(d); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cnt);
    cnt = 0;
    while (!done && cnt < 2000) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  task automatic run_one(int n, int m, int d);
    int cnt;
    pulse_start(n, m, d);
    wait_done(cnt);
    if (d == 0 || m < 2) check("R9 edge value", int'(result), ref_pow(n, m, d));
    else                 check("R2 R7 R8 value", int'(result), ref_pow(n, m, d));
    check("R4 R6 latency", cnt, ref_len(d));
  endtask

  int mods[3] = '{3, 13, 251};
  int exps[8] = '{0, 1, 2, 128, 255, 165, 90, 7};

  initial begin
    int cnt, held;
    repeat (3) @(negedge clk);
    check("R1 done after reset", int'(done), 0);
    check("R1 result after reset", int'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int ni = 0; ni < 3; ni++) begin
      for (int m = 0; m < mods[ni]; m += ((mods[ni] > 20) ? 25 : 1)) begin
        for (int di = 0; di < 8; di++) run_one(mods[ni], m, exps[di]);
      end
    end
    run_one(251, 250, 255);
    run_one(251, 1, 200);
    run_one(13, 0, 9);

    // R3: disturb inputs and pulse start while busy
    pulse_start(251, 77, 173);
    repeat (40) @(negedge clk);
    modulus = W'(13); base = W'(5); expo = EW'(3); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (60) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(cnt);
    check("R3 mid-run value", int'(result), ref_pow(251, 77, 173));
    check("R3 mid-run latency", cnt + 102, ref_len(173));

    // R5: result and done hold without start
    held = int'(result);
    modulus = W'(3); base = W'(2); expo = EW'(1);
    repeat (25) @(negedge clk);
    check("R5 done held", int'(done), 1);
    check("R5 result held", int'(result), held);

    // R3: start clears done on acceptance
    pulse_start(13, 4, 6);
    check("R3 done cleared", int'(done), 0);
    wait_done(cnt);
    check("R3 restart value", int'(result), ref_pow(13, 4, 6));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule